// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the command side of an SDRAM-style memory and reads the three active-low strobes (row strobe, column strobe, write enable) together with the bank select and the row/column address lines. It samples them on every rising clock edge and turns each sample into one decoded command. It keeps an open or idle flag and the open row for every bank. It also keeps a per-bank countdown that enforces the activate-to-column delay. A column command is forwarded only when its bank is open and that delay has run out. A refresh is forwarded only when every bank is idle.

A refresh command carries no bank number. The block supplies its own target from an internal counter. The bank number sits in the low bits of that counter and the row (word) number in the upper bits. Every accepted refresh advances the counter by one, so the bank number steps first and the row number steps once all banks have been visited. An illegal command is not forwarded. Instead it raises a violation flag for one cycle. Every result appears on the registered outputs one clock after the edge that sampled the command.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Strobes (ras_n,cas_n,we_n)=(0,1,1) to an idle bank open that bank with the row on addr. One cycle later, cmd_valid=1, cmd_code=1, cmd_bank=bank and cmd_row=addr.
- R2: Strobes (1,0,1) are a read (cmd_code=2) and (1,0,0) are a write (cmd_code=3). When accepted, cmd_bank is the addressed bank and cmd_row is the row that bank has open.
- R3: A column command is accepted only if at least rcd_cycles rising edges have passed since its bank's activate. If rcd_cycles is 0 or 1, a column command on the next edge is accepted.
- R4: A column command to an idle bank, or one issued too early, is not forwarded. It gives violation=1 for one cycle with cmd_valid=0.
- R5: Strobes (0,0,1) are a refresh. It is accepted only when all banks are idle. Otherwise violation=1 and the refresh counter does not move.
- R6: An accepted refresh gives cmd_code=5, with cmd_bank taken from the low counter bits and cmd_row from the upper counter bits. The counter then increments, so the bank steps first and the row steps after the last bank.
- R7: Strobes (0,1,0) are a precharge (cmd_code=4). It is always forwarded and returns the addressed bank to idle.
- R8: No-operation (1,1,1) and the other strobe patterns (1,1,0) and (0,0,0) give cmd_valid=0 and violation=0 and change no bank state.
- R9: An activate to a bank that is already open is a violation and is not forwarded.
- R10: While rst is high at a rising edge, all banks become idle, all delay timers and the refresh counter clear, and the outputs read cmd_valid=0, violation=0 one cycle later.
- R11: cmd_valid and violation are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BA_W | Bank select |
| addr | input | ROW_W | Row or column address |
| rcd_cycles | input | RCD_W | Activate-to-column delay in clocks |
| cmd_valid | output | 1 | Decoded command forwarded this cycle |
| cmd_code | output | 3 | 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmd_bank | output | BA_W | Target bank |
| cmd_row | output | ROW_W | Target row |
| violation | output | 1 | One-cycle protocol violation pulse |

## Verification
Two functions can fall on the same edge: the activate-to-column countdown of a bank reaching zero, and a column command arriving for that bank. The bench issues the column command one edge before the delay has passed and again on the exact edge where it has passed, while a second bank's activate sits in between. It expects a violation on the early attempt and a forwarded command carrying the open row on the boundary edge. The same reasoning covers a refresh that meets a bank still open: the bench expects it to be rejected until both precharges have gone through, and then to carry counter values that the bench tracks on its own.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  parameter int RCD_W = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  bank,
  input  logic [ROW_W-1:0] addr,
  input  logic [RCD_W-1:0] rcd_cycles,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic             violation
);
  localparam int CNT_W = BA_W + ROW_W;
  localparam logic [RCD_W-1:0] T_ONE = 1;
  localparam logic [CNT_W-1:0] C_ONE = 1;

  logic [BANKS-1:0] bank_open;
  logic [ROW_W-1:0] open_row [BANKS];
  logic [RCD_W-1:0] rcd_left [BANKS];
  logic [CNT_W-1:0] ref_cnt;

  wire is_act = !ras_n &&  cas_n &&  we_n;
  wire is_col =  ras_n && !cas_n;
  wire is_pre = !ras_n &&  cas_n && !we_n;
  wire is_ref = !ras_n && !cas_n &&  we_n;

  wire sel_open  = bank_open[bank];
  wire sel_ready = rcd_left[bank] == '0;
  wire act_ok = is_act && !sel_open;
  wire col_ok = is_col && sel_open && sel_ready;
  wire ref_ok = is_ref && bank_open == '0;
  wire bad    = (is_act && sel_open) || (is_col && !(sel_open && sel_ready))
              || (is_ref && bank_open != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= '0;
      ref_cnt   <= '0;
      for (int b = 0; b < BANKS; b++) begin
        open_row[b] <= '0;
        rcd_left[b] <= '0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++)
        if (rcd_left[b] != '0) rcd_left[b] <= rcd_left[b] - T_ONE;
      if (act_ok) begin
        bank_open[bank] <= 1'b1;
        open_row[bank]  <= addr;
        rcd_left[bank]  <= (rcd_cycles == '0) ? '0 : rcd_cycles - T_ONE;
      end
      if (is_pre) bank_open[bank] <= 1'b0;
      if (ref_ok) ref_cnt <= ref_cnt + C_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      violation <= 1'b0;
      cmd_code  <= 3'd0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
    end else begin
      cmd_valid <= act_ok || col_ok || is_pre || ref_ok;
      violation <= bad;
      cmd_bank  <= ref_ok ? ref_cnt[BA_W-1:0] : bank;
      if (act_ok)      begin cmd_code <= 3'd1; cmd_row <= addr; end
      else if (col_ok) begin cmd_code <= we_n ? 3'd2 : 3'd3; cmd_row <= open_row[bank]; end
      else if (is_pre) begin cmd_code <= 3'd4; cmd_row <= '0; end
      else if (ref_ok) begin cmd_code <= 3'd5; cmd_row <= ref_cnt[CNT_W-1:BA_W]; end
      else             begin cmd_code <= 3'd0; cmd_row <= '0; end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic                 violation,
  input logic [BANKS-1:0]     bank_open,
  input logic [BA_W+ROW_W-1:0] ref_cnt
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && violation));

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !violation));

  a_r8_nop_silent: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n && we_n) |=> (!cmd_valid && !violation));

  a_r2_read_code: assert property (@(posedge clk) disable iff (rst)
    (ras_n && !cas_n && we_n) |=> (!cmd_valid || cmd_code == 3'd2));

  a_r5_ref_all_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 3'd5) |-> ($past(bank_open) == '0));

  a_r6_ref_advance: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 3'd5) |-> (ref_cnt == $past(ref_cnt) + 1'b1));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BANKS(BANKS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .violation(violation),
  .bank_open(bank_open), .ref_cnt(ref_cnt));

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
  logic clk = 0, rst = 1;
  logic ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] bank = 0;
  logic [11:0] addr = 0;
  logic [3:0] rcd_cycles = 4'd3;
  logic cmd_valid, violation;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [11:0] cmd_row;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker dut_i (.clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .addr(addr), .rcd_cycles(rcd_cycles), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .violation(violation));

  // {strobes, bank, addr, exp_valid, exp_code, exp_bank, exp_row, exp_viol}
  localparam int N = 17;
  localparam logic [35:0] VEC [N] = '{
    {3'b111, 2'd0, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b0}, // R8 nop
    {3'b011, 2'd0, 12'h123, 1'b1, 3'd1, 2'd0, 12'h123, 1'b0}, // R1 act b0
    {3'b101, 2'd0, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}, // R3 too early
    {3'b011, 2'd1, 12'h0AB, 1'b1, 3'd1, 2'd1, 12'h0AB, 1'b0}, // R1 act b1
    {3'b101, 2'd0, 12'h000, 1'b1, 3'd2, 2'd0, 12'h123, 1'b0}, // R3 boundary read
    {3'b100, 2'd1, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}, // R3 early write
    {3'b100, 2'd1, 12'h000, 1'b1, 3'd3, 2'd1, 12'h0AB, 1'b0}, // R2 write b1
    {3'b101, 2'd2, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}, // R4 idle bank
    {3'b001, 2'd0, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}, // R5 banks open
    {3'b010, 2'd0, 12'h000, 1'b1, 3'd4, 2'd0, 12'h000, 1'b0}, // R7 pre b0
    {3'b101, 2'd0, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}, // R7 b0 idle now
    {3'b010, 2'd1, 12'h000, 1'b1, 3'd4, 2'd1, 12'h000, 1'b0}, // R7 pre b1
    {3'b001, 2'd3, 12'h000, 1'b1, 3'd5, 2'd0, 12'h000, 1'b0}, // R6 ref 0/0
    {3'b001, 2'd0, 12'h000, 1'b1, 3'd5, 2'd1, 12'h000, 1'b0}, // R6 ref b1
    {3'b110, 2'd0, 12'h000, 1'b0, 3'd0, 2'd0, 12'h000, 1'b0}, // R8 other pattern
    {3'b011, 2'd3, 12'hFFF, 1'b1, 3'd1, 2'd3, 12'hFFF, 1'b0}, // R1 act b3
    {3'b011, 2'd3, 12'h001, 1'b0, 3'd0, 2'd0, 12'h000, 1'b1}  // R9 reopen
  };

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic drive(logic [2:0] s, logic [1:0] b, logic [11:0] a);
    {ras_n, cas_n, we_n} = s; bank = b; addr = a;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_cmd(string req, logic v, logic [2:0] c, logic [1:0] b, logic [11:0] r, logic x);
    chk({req, " valid"}, cmd_valid, v);
    chk({req, " viol"}, violation, x);
    if (v) begin
      chk({req, " code"}, cmd_code, c);
      chk({req, " bank"}, cmd_bank, b);
      if (c != 3'd4) chk({req, " row"}, cmd_row, r);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset valid", cmd_valid, 0);
    chk("R10 reset viol", violation, 0);
    rst = 0;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][35:33], VEC[i][32:31], VEC[i][30:19]);
      expect_cmd($sformatf("vec%0d R1-R9", i), VEC[i][18], VEC[i][17:15], VEC[i][14:13], VEC[i][12:1], VEC[i][0]);
      chk("R11 exclusive", int'(cmd_valid && violation), 0);
    end
    rcd_cycles = 4'd0;
    drive(3'b011, 2'd2, 12'h055); expect_cmd("R3 zero-delay act", 1, 3'd1, 2'd2, 12'h055, 0);
    drive(3'b101, 2'd2, 12'h000); expect_cmd("R3 zero-delay read", 1, 3'd2, 2'd2, 12'h055, 0);
    drive(3'b010, 2'd2, 12'h000); expect_cmd("R7 pre b2", 1, 3'd4, 2'd2, 12'h000, 0);
    drive(3'b010, 2'd3, 12'h000); expect_cmd("R7 pre b3", 1, 3'd4, 2'd3, 12'h000, 0);
    drive(3'b001, 2'd0, 12'h000); expect_cmd("R6 ref b2", 1, 3'd5, 2'd2, 12'h000, 0);
    drive(3'b001, 2'd0, 12'h000); expect_cmd("R6 ref b3", 1, 3'd5, 2'd3, 12'h000, 0);
    drive(3'b001, 2'd0, 12'h000); expect_cmd("R6 ref row step", 1, 3'd5, 2'd0, 12'h001, 0);
    drive(3'b000, 2'd0, 12'h000); expect_cmd("R8 mode pattern", 0, 3'd0, 2'd0, 12'h000, 0);
    drive(3'b011, 2'd0, 12'h0CC); expect_cmd("R1 act before reset", 1, 3'd1, 2'd0, 12'h0CC, 0);
    rst = 1;
    drive(3'b111, 2'd0, 12'h000); expect_cmd("R10 in reset", 0, 3'd0, 2'd0, 12'h000, 0);
    rst = 0;
    drive(3'b101, 2'd0, 12'h000); expect_cmd("R10 bank idle after reset", 0, 3'd0, 2'd0, 12'h000, 1);
    drive(3'b001, 2'd0, 12'h000); expect_cmd("R10 counter cleared", 1, 3'd5, 2'd0, 12'h000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule